// File: doc/BRIEF.md
# Rectifying Envelope Follower

This block tracks the amplitude envelope of a signed sample stream. Each valid sample is rectified to a magnitude. The magnitude then feeds a one-pole low-pass filter that needs no multiplier. On every valid sample, the filter accumulator loses a power-of-two fraction of its own value and gains the new magnitude. The output is the accumulator scaled back down by the same power of two, so it reads in the same units as the mean magnitude of the input.

A second mode takes an in-phase and a quadrature sample together and filters their power, I² + Q². Downstream logic can then work in squared-envelope units and needs no square root. The decay shift is a parameter. It is chosen from the sample rate and the cutoff wanted: the time constant is about 2^SHIFT samples.

Top module: `env_follower`

## Requirements
- R1: A synchronous reset held over a clock edge clears the accumulator, so `env_out` reads 0 afterwards.
- R2: In magnitude mode (`sq_mode` = 0), each valid sample updates the accumulator A to A − floor(A / 2^SHIFT) + |I|. `env_out` equals floor(A / 2^SHIFT), and `in_q` has no effect.
- R3: Rectification is full-wave: a negative sample contributes its negation, so −v and +v give identical outputs.
- R4: The most negative input code (−2^(DATA_W−1)) contributes 2^(DATA_W−1) − 1, the largest positive magnitude, in both modes.
- R5: In power mode (`sq_mode` = 1), each valid sample contributes |I|² + |Q|², using the saturated magnitudes of R4, through the same update as R2.
- R6: While `in_valid` is low, the accumulator holds and `env_out` does not change, whatever the other inputs do.
- R7: The accumulator never overflows. A constant contribution m, applied from reset, settles `env_out` to exactly m. `env_out` never exceeds the largest possible contribution, 2·(2^(DATA_W−1) − 1)².
- R8: A steady sine of amplitude A in magnitude mode settles `env_out` to within 6 % of A of 2A/π.
- R9: When a valid contribution is at or above the current output, the output does not fall. When it is at or below, the output does not rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe; the update happens only when high |
| in_i | input | DATA_W | Signed sample, or the in-phase part in power mode |
| in_q | input | DATA_W | Signed quadrature sample, used only in power mode |
| sq_mode | input | 1 | 0 = magnitude envelope, 1 = envelope squared (power) |
| env_out | output | 2*DATA_W-1 | Unsigned filtered envelope, zero-extended in magnitude mode |

## Verification
A wrong accumulator state shows at `env_out` on the clock edge after the valid sample that caused it, because the output is a plain slice of the accumulator. Rounding or rectification slips therefore appear as a one-sample mismatch against the reference update. A leak of the wrong size shows in a different way. The per-sample values drift apart slowly, and the settled value of a constant input (exactly m) or a sine (2A/π) lands in the wrong place only after several hundred samples.

// File: rtl/env_pkg.sv
package env_pkg;
    typedef enum logic {
        DET_MAG = 1'b0,
        DET_POW = 1'b1
    } det_mode_e;
endpackage

// File: rtl/env_abs_sat.sv
module env_abs_sat #(
    parameter int W = 12
) (
    input  logic signed [W-1:0] x,
    output logic        [W-2:0] mag
);
    localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic signed [W-1:0] neg_x;

    always_comb begin
        neg_x = -x;
        if (x == MOST_NEG) begin
            mag = '1;
        end else if (x[W-1]) begin
            mag = neg_x[W-2:0];
        end else begin
            mag = x[W-2:0];
        end
    end

    // R3: rectification keeps zero as zero and nonzero as nonzero
    always_comb begin
        assert_abs_zero_R3: assert ((x == '0) == (mag == '0));
    end
endmodule

// File: rtl/env_detect.sv
module env_detect
    import env_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int MAG_W = DATA_W - 1,
    localparam int SQ_W  = 2 * MAG_W + 1
) (
    input  logic signed [DATA_W-1:0] i_smp,
    input  logic signed [DATA_W-1:0] q_smp,
    input  det_mode_e                mode,
    output logic        [SQ_W-1:0]   contrib
);
    localparam int NCH = 2;

    logic signed [DATA_W-1:0] chan_x   [NCH];
    logic        [MAG_W-1:0]  chan_mag [NCH];
    logic        [2*MAG_W-1:0] chan_sq [NCH];

    assign chan_x[0] = i_smp;
    assign chan_x[1] = q_smp;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        env_abs_sat #(.W(DATA_W)) u_abs (
            .x   (chan_x[ch]),
            .mag (chan_mag[ch])
        );
        assign chan_sq[ch] = chan_mag[ch] * chan_mag[ch];
    end

    always_comb begin
        if (mode == DET_POW) begin
            contrib = SQ_W'(chan_sq[0]) + SQ_W'(chan_sq[1]);
        end else begin
            contrib = SQ_W'(chan_mag[0]);
        end
    end
endmodule

// File: rtl/env_leaky_int.sv
module env_leaky_int #(
    parameter int IN_W  = 23,
    parameter int SHIFT = 6,
    localparam int ACC_W = IN_W + SHIFT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            valid,
    input  logic [IN_W-1:0] sample,
    output logic [IN_W-1:0] env
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } int_state_t;

    int_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (valid) begin
            st_d.acc = st_q.acc - ACC_W'(st_q.acc[ACC_W-1:SHIFT]) + ACC_W'(sample);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign env = st_q.acc[ACC_W-1:SHIFT];

    // R6: no strobe, no movement
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !valid |=> $stable(env));

    // R9: output moves toward the contribution, never away from it
    assert_rise_toward_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && sample >= env) |=> env >= $past(env));

    assert_fall_toward_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && sample <= env) |=> env <= $past(env));
endmodule

// File: rtl/env_follower.sv
module env_follower
    import env_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int SHIFT  = 6,
    localparam int MAG_W = DATA_W - 1,
    localparam int SQ_W  = 2 * MAG_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    input  logic                     sq_mode,
    output logic        [SQ_W-1:0]   env_out
);
    localparam logic [SQ_W-1:0] CONTRIB_MAX =
        SQ_W'((64'd1 << (2*MAG_W+1)) - (64'd1 << (MAG_W+2)) + 64'd2);

    logic      [SQ_W-1:0] contrib;
    det_mode_e            mode;

    assign mode = det_mode_e'(sq_mode);

    env_detect #(.DATA_W(DATA_W)) u_detect (
        .i_smp   (in_i),
        .q_smp   (in_q),
        .mode    (mode),
        .contrib (contrib)
    );

    env_leaky_int #(.IN_W(SQ_W), .SHIFT(SHIFT)) u_lpf (
        .clk    (clk),
        .rst    (rst),
        .valid  (in_valid),
        .sample (contrib),
        .env    (env_out)
    );

    // R7: accumulator growth is bounded by the largest contribution
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        env_out <= CONTRIB_MAX);

    // R7: a contribution never exceeds the power-mode ceiling
    assert_contrib_bound_R7: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> contrib <= CONTRIB_MAX);
endmodule

// File: tb/env_follower_test.sv
module env_follower_test;
    localparam int DATA_W = 12;
    localparam int SHIFT  = 6;
    localparam int SQ_W   = 2 * DATA_W - 1;
    localparam int MAXMAG = (1 << (DATA_W - 1)) - 1;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     in_valid = 1'b0;
    logic signed [DATA_W-1:0] in_i = '0;
    logic signed [DATA_W-1:0] in_q = '0;
    logic                     sq_mode = 1'b0;
    logic        [SQ_W-1:0]   env_out;

    int checks = 0;
    int fails  = 0;
    longint model_acc = 0;
    bit done = 0;

    always #5 clk = ~clk;

    env_follower #(.DATA_W(DATA_W), .SHIFT(SHIFT)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i),
        .in_q(in_q), .sq_mode(sq_mode), .env_out(env_out)
    );

    function automatic longint mag_of(input int x);
        if (x == -(MAXMAG + 1)) return MAXMAG;
        return (x < 0) ? -x : x;
    endfunction

    function automatic longint contrib_of(input int i, input int q, input bit pw);
        if (pw) return mag_of(i) * mag_of(i) + mag_of(q) * mag_of(q);
        return mag_of(i);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input longint act,
                               input longint lo, input longint hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_acc = 0;
        check("R1", env_out, 0);
    endtask

    // drive one cycle, update the reference, compare after the edge
    task automatic step(input bit v, input int i, input int q, input bit pw,
                        input string req);
        @(negedge clk);
        in_valid = v; in_i = DATA_W'(i); in_q = DATA_W'(q); sq_mode = pw;
        @(posedge clk);
        if (v) model_acc = model_acc - (model_acc >>> SHIFT) + contrib_of(i, q, pw);
        #2;
        check(req, env_out, model_acc >>> SHIFT);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(10 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed_dummy;
        longint held;
        seed_dummy = $urandom(1234);

        do_reset();   // R1

        // R2: constant magnitude, junk on Q must not matter
        for (int k = 0; k < 700; k++) step(1, 500, $urandom % 4096 - 2048, 0, "R2");
        check("R7 settle 500", env_out, 500);

        // R6: no strobe, inputs wiggle
        held = env_out;
        for (int k = 0; k < 20; k++) begin
            step(0, $urandom % 4096 - 2048, $urandom % 4096 - 2048, $urandom % 2, "R6");
            check("R6 hold", env_out, held);
        end

        // R3: negative input gives the same settled value
        do_reset();
        for (int k = 0; k < 700; k++) step(1, -500, 0, 0, "R3");
        check("R3 settle -500", env_out, 500);

        // R4: most negative code in magnitude mode
        do_reset();
        for (int k = 0; k < 1000; k++) step(1, -2048, 0, 0, "R4");
        check("R4 settle", env_out, MAXMAG);

        // R5: power mode, 300^2 + 400^2
        do_reset();
        for (int k = 0; k < 1500; k++) step(1, 300, -400, 1, "R5");
        check("R5 settle", env_out, 250000);

        // R4/R5/R7: power mode ceiling
        do_reset();
        for (int k = 0; k < 1500; k++) step(1, -2048, -2048, 1, "R7");
        check("R7 ceiling", env_out, 2 * MAXMAG * MAXMAG);

        // R8: sine of amplitude 1000, period 25 samples
        do_reset();
        for (int k = 0; k < 2000; k++) begin
            int s;
            s = int'($rtoi(1000.0 * $sin(2.0 * 3.14159265358979 * k / 25.0)));
            step(1, s, 0, 0, "R8 track");
            if (k >= 1500 && (k % 10) == 0)
                check_range("R8 envelope", env_out, 637 - 60, 637 + 60);
        end

        // R2..R6, R9: random mixed stimulus against the reference
        do_reset();
        for (int k = 0; k < 600; k++) begin
            int ri, rq;
            ri = int'($urandom % 4096) - 2048;
            rq = int'($urandom % 4096) - 2048;
            if ($urandom % 16 == 0) ri = -2048;
            step(($urandom % 4) != 0, ri, rq, (k / 150) % 2 == 1, "R9 random");
        end

        // R1: reset from a loaded state
        do_reset();

        done = 1;
        finish_run();
    end
endmodule